// File: doc/BRIEF.md
# Floating-Point Compare to Condition Field

This block compares two IEEE-754 operands and records the outcome as a 4-bit
field inside a 32-bit condition register. It has three formats. A scalar single
compare works on the low 32 bits of each operand. A scalar double compare works
on all 64 bits. A paired-single compare runs two independent 32-bit lanes side
by side. A 2-bit test code picks the relation to test (equal, greater-than or
less-than), and a 3-bit index picks which nibble of the condition register
receives the result.

Every operand pair falls into one of four classes: less, equal, greater or
unordered. A pair is unordered when either side is a NaN. An unordered compare
that involves a signaling NaN raises an invalid flag. The compare itself is
combinational. The condition register and the invalid flag are registered, and
they change only on a cycle where the input strobe is high. An update rewrites
only the selected nibble of the register.

Top module: `fp_cond_cmp`

## Requirements
- R1: After reset, `condReg` is 0 and `invalidFlag` is 0.
- R2: Mode 00 compares `opA[31:0]` with `opB[31:0]` as single precision, and mode 11 does the same. The test codes are 00 equal, 01 greater-than (A > B), 10 less-than (A < B), and 11 never matches. The written field is 4'b0100 when the relation holds and 4'b0000 when it does not.
- R3: Mode 01 compares `opA` and `opB` as 64-bit double precision values. The field takes the same values as in R2.
- R4: An operand whose exponent is all ones and whose fraction is nonzero is a NaN. A compare that involves a NaN is unordered, and no test code matches it.
- R5: +0 and -0 compare equal. Subnormal values are ordered by their magnitude and sign, like any other value.
- R6: Mode 10 compares two single-precision lanes: high is `[63:32]` and low is `[31:0]`. With ch as the high-lane match and cl as the low-lane match, the field is {ch, cl, ch|cl, ch&cl}, from its MSB to its LSB.
- R7: Field index f writes `condReg` bits [31-4f : 28-4f], so f=0 selects the top nibble and f=7 selects bits 3:0.
- R8: A compare leaves every `condReg` bit outside the selected nibble unchanged.
- R9: In a cycle where `inValid` is low, both `condReg` and `invalidFlag` keep their values.
- R10: Every valid compare loads `invalidFlag`. It is set when any compared lane is unordered and one of that lane's operands is a signaling NaN (a NaN whose fraction MSB is 0). A quiet NaN alone leaves the flag at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Compare strobe; updates the registers |
| mode | input | 2 | 00 single, 01 double, 10 paired single, 11 single |
| testSel | input | 2 | 00 equal, 01 greater, 10 less, 11 none |
| fieldIdx | input | 3 | Destination nibble index |
| opA | input | 64 | First operand |
| opB | input | 64 | Second operand |
| condReg | output | 32 | Condition register |
| invalidFlag | output | 1 | Invalid flag of the last compare |

## Verification
Random operands seldom produce a NaN or a signed zero, and in paired mode they almost never produce two lanes that disagree in the way that separates the OR bit from the AND bit. The stimulus therefore draws each lane from a pool that mixes signed zeros, infinities, quiet and signaling NaNs, subnormals and random words. It often reuses one operand as the other, or flips its sign, so that equal and sign-only differences come up. Directed cases first place a signaling NaN in only one lane and write the two end nibbles. Every transaction is then checked against a model built from ordering keys.

// File: rtl/fpcc_pkg.sv
package fpcc_pkg;
  localparam int REG_W      = 32;
  localparam int FIELD_W    = 4;
  localparam int NUM_FIELDS = REG_W / FIELD_W;
  localparam int IDX_W      = $clog2(NUM_FIELDS);
  localparam int SH_W       = $clog2(REG_W);
  localparam int FSH_W      = $clog2(FIELD_W);
  localparam int SP_EXP     = 8;
  localparam int SP_FRAC    = 23;
  localparam int DP_EXP     = 11;
  localparam int DP_FRAC    = 52;
  localparam int LANE_W     = 1 + SP_EXP + SP_FRAC;
  localparam int NUM_LANES  = 2;
  localparam int OP_W       = 1 + DP_EXP + DP_FRAC;

  typedef enum logic [1:0] {
    REL_LT = 2'd0,
    REL_EQ = 2'd1,
    REL_GT = 2'd2,
    REL_UN = 2'd3
  } relation_t;

  typedef struct packed {
    logic       load;
    logic       vec;
    logic       dbl;
    logic [1:0] test;
  } cmpStrobe_t;
endpackage

// File: rtl/fpcc_lane.sv
module fpcc_lane
  import fpcc_pkg::*;
#(
  parameter int EXP_W  = 8,
  parameter int FRAC_W = 23,
  localparam int W     = 1 + EXP_W + FRAC_W
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output relation_t    rel,
  output logic         sigInvalid
);
  logic aNan, bNan, aSnan, bSnan, bothZero;
  logic [W-2:0] magA, magB;

  always_comb begin
    magA     = a[W-2:0];
    magB     = b[W-2:0];
    aNan     = (&a[W-2:FRAC_W]) && (|a[FRAC_W-1:0]);
    bNan     = (&b[W-2:FRAC_W]) && (|b[FRAC_W-1:0]);
    aSnan    = aNan && !a[FRAC_W-1];
    bSnan    = bNan && !b[FRAC_W-1];
    bothZero = (magA == '0) && (magB == '0);
    if (aNan || bNan)                rel = REL_UN;
    else if (bothZero)               rel = REL_EQ;
    else if (a[W-1] != b[W-1])       rel = a[W-1] ? REL_LT : REL_GT;
    else if (magA == magB)           rel = REL_EQ;
    else if ((magA > magB) ^ a[W-1]) rel = REL_GT;
    else                             rel = REL_LT;
    sigInvalid = (rel == REL_UN) && (aSnan || bSnan);
  end
endmodule

// File: rtl/fpcc_control.sv
module fpcc_control
  import fpcc_pkg::*;
(
  input  logic       inValid,
  input  logic [1:0] mode,
  input  logic [1:0] testSel,
  output cmpStrobe_t stb
);
  always_comb begin
    stb.load = inValid;
    stb.vec  = (mode == 2'b10);
    stb.dbl  = (mode == 2'b01);
    stb.test = testSel;
  end
endmodule

// File: rtl/fpcc_datapath.sv
module fpcc_datapath
  import fpcc_pkg::*;
(
  input  logic             clk,
  input  logic             rstN,
  input  cmpStrobe_t       stb,
  input  logic [IDX_W-1:0] fieldIdx,
  input  logic [OP_W-1:0]  opA,
  input  logic [OP_W-1:0]  opB,
  output logic [REG_W-1:0] condReg,
  output logic             invalidFlag
);
  relation_t laneRel [NUM_LANES];
  logic [NUM_LANES-1:0] laneInv, laneMatch;
  relation_t dblRel;
  logic dblInv, dblMatch;
  logic scalarMatch, nextInv;
  logic [FIELD_W-1:0] fieldVal;
  logic [SH_W-1:0] shiftAmt;
  logic [REG_W-1:0] fieldMask;

  function automatic logic relHits(relation_t r, logic [1:0] t);
    case (t)
      2'b00:   return r == REL_EQ;
      2'b01:   return r == REL_GT;
      2'b10:   return r == REL_LT;
      default: return 1'b0;
    endcase
  endfunction

  for (genvar g = 0; g < NUM_LANES; g++) begin : g_lane
    fpcc_lane #(.EXP_W(SP_EXP), .FRAC_W(SP_FRAC)) i_lane (
      .a(opA[g*LANE_W +: LANE_W]),
      .b(opB[g*LANE_W +: LANE_W]),
      .rel(laneRel[g]),
      .sigInvalid(laneInv[g])
    );
    assign laneMatch[g] = relHits(laneRel[g], stb.test);
  end

  fpcc_lane #(.EXP_W(DP_EXP), .FRAC_W(DP_FRAC)) i_dbl (
    .a(opA), .b(opB), .rel(dblRel), .sigInvalid(dblInv)
  );
  assign dblMatch = relHits(dblRel, stb.test);

  always_comb begin
    scalarMatch = stb.dbl ? dblMatch : laneMatch[0];
    if (stb.vec) begin
      fieldVal = {laneMatch[1], laneMatch[0],
                  laneMatch[1] | laneMatch[0], laneMatch[1] & laneMatch[0]};
      nextInv  = |laneInv;
    end else begin
      fieldVal = {1'b0, scalarMatch, 2'b00};
      nextInv  = stb.dbl ? dblInv : laneInv[0];
    end
    shiftAmt  = SH_W'({~fieldIdx, {FSH_W{1'b0}}});
    fieldMask = {{(REG_W-FIELD_W){1'b0}}, {FIELD_W{1'b1}}} << shiftAmt;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      condReg     <= '0;
      invalidFlag <= 1'b0;
    end else if (stb.load) begin
      condReg     <= (condReg & ~fieldMask) |
                     ({{(REG_W-FIELD_W){1'b0}}, fieldVal} << shiftAmt);
      invalidFlag <= nextInv;
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (!rstN)
    !stb.load |=> $stable(condReg) && $stable(invalidFlag));

  p_keep_others_r8: assert property (@(posedge clk) disable iff (!rstN)
    stb.load |=> ((condReg ^ $past(condReg)) & ~$past(fieldMask)) == '0);

  p_scalar_shape_r2: assert property (@(posedge clk) disable iff (!rstN)
    stb.load && !stb.vec |=>
      ((condReg >> $past(shiftAmt)) & 32'hB) == '0);

  p_vec_or_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.load && stb.vec |=>
      ((((condReg >> $past(shiftAmt)) & 32'h2) != '0) ==
       (((condReg >> $past(shiftAmt)) & 32'hC) != '0)));

  p_vec_and_r6: assert property (@(posedge clk) disable iff (!rstN)
    stb.load && stb.vec |=>
      ((((condReg >> $past(shiftAmt)) & 32'h1) != '0) ==
       (((condReg >> $past(shiftAmt)) & 32'hC) == 32'hC)));
endmodule

// File: rtl/fp_cond_cmp.sv
module fp_cond_cmp
  import fpcc_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        inValid,
  input  logic [1:0]  mode,
  input  logic [1:0]  testSel,
  input  logic [2:0]  fieldIdx,
  input  logic [63:0] opA,
  input  logic [63:0] opB,
  output logic [31:0] condReg,
  output logic        invalidFlag
);
  cmpStrobe_t stb;

  fpcc_control i_ctrl (
    .inValid(inValid), .mode(mode), .testSel(testSel), .stb(stb)
  );

  fpcc_datapath i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .fieldIdx(fieldIdx),
    .opA(opA), .opB(opB), .condReg(condReg), .invalidFlag(invalidFlag)
  );
endmodule

// File: tb/test_fp_cond_cmp.sv
`timescale 1ns/1ps
module test_fp_cond_cmp;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic inValid = 1'b0;
  logic [1:0] mode = '0, testSel = '0;
  logic [2:0] fieldIdx = '0;
  logic [63:0] opA = '0, opB = '0;
  logic [31:0] condReg;
  logic invalidFlag;
  int checks = 0, errors = 0;
  logic [31:0] modelReg = '0;
  logic modelInv = 1'b0;

  always #2.5 clk = ~clk;

  fp_cond_cmp i_fp_cond_cmp (
    .clk(clk), .rstN(rstN), .inValid(inValid), .mode(mode),
    .testSel(testSel), .fieldIdx(fieldIdx), .opA(opA), .opB(opB),
    .condReg(condReg), .invalidFlag(invalidFlag)
  );

  function automatic bit isNan(logic [63:0] x, bit dbl);
    if (dbl) return (x[62:52] == 11'h7ff) && (x[51:0] != 0);
    return (x[30:23] == 8'hff) && (x[22:0] != 0);
  endfunction

  function automatic bit isSnan(logic [63:0] x, bit dbl);
    return isNan(x, dbl) && !(dbl ? x[51] : x[22]);
  endfunction

  function automatic logic [63:0] orderKey(logic [63:0] x, bit dbl);
    logic [63:0] v = dbl ? x : {x[31:0], 32'h0};
    if (v[62:0] == 0) v = 64'h0;
    return v[63] ? ~v : (v | 64'h8000_0000_0000_0000);
  endfunction

  // 0 less, 1 equal, 2 greater, 3 unordered
  function automatic int refRel(logic [63:0] a, logic [63:0] b, bit dbl);
    logic [63:0] ka, kb;
    if (isNan(a, dbl) || isNan(b, dbl)) return 3;
    ka = orderKey(a, dbl);
    kb = orderKey(b, dbl);
    if (ka == kb) return 1;
    return (ka > kb) ? 2 : 0;
  endfunction

  function automatic bit refMatch(logic [63:0] a, logic [63:0] b, bit dbl, logic [1:0] t);
    int r = refRel(a, b, dbl);
    return (t == 2'd0 && r == 1) || (t == 2'd1 && r == 2) || (t == 2'd2 && r == 0);
  endfunction

  function automatic bit refInv(logic [63:0] a, logic [63:0] b, bit dbl);
    return (refRel(a, b, dbl) == 3) && (isSnan(a, dbl) || isSnan(b, dbl));
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic doTxn(bit v, logic [1:0] m, logic [1:0] t, logic [2:0] idx,
                       logic [63:0] a, logic [63:0] b, string req);
    logic [3:0] fv;
    bit inv;
    int sh;
    if (m == 2'b10) begin
      bit ch = refMatch({32'h0, a[63:32]}, {32'h0, b[63:32]}, 0, t);
      bit cl = refMatch({32'h0, a[31:0]}, {32'h0, b[31:0]}, 0, t);
      fv  = {ch, cl, ch | cl, ch & cl};
      inv = refInv({32'h0, a[63:32]}, {32'h0, b[63:32]}, 0) ||
            refInv({32'h0, a[31:0]}, {32'h0, b[31:0]}, 0);
    end else begin
      bit dbl = (m == 2'b01);
      fv  = {1'b0, refMatch(a, b, dbl, t), 2'b00};
      inv = refInv(a, b, dbl);
    end
    if (v) begin
      sh = (7 - int'(idx)) * 4;
      modelReg = (modelReg & ~(32'hF << sh)) | (32'(fv) << sh);
      modelInv = inv;
    end
    inValid = v; mode = m; testSel = t; fieldIdx = idx; opA = a; opB = b;
    @(posedge clk);
    @(negedge clk);
    check({req, " condReg"}, {32'h0, condReg}, {32'h0, modelReg});
    check({req, " R10 invalidFlag"}, {63'h0, invalidFlag}, {63'h0, modelInv});
  endtask

  function automatic logic [31:0] pickSp();
    case ($urandom % 9)
      0: return 32'h0000_0000;
      1: return 32'h8000_0000;
      2: return 32'h7f80_0000;
      3: return 32'hff80_0000;
      4: return 32'h7fc0_0001 | ($urandom & 32'h8000_0000);
      5: return 32'h7f80_0001 | ($urandom & 32'h8020_0000) & 32'hffbf_ffff;
      6: return ($urandom & 32'h8000_000f);
      7: return 32'h3f80_0000 | ($urandom & 32'h8000_0003);
      default: return $urandom;
    endcase
  endfunction

  function automatic logic [63:0] pickDp();
    case ($urandom % 8)
      0: return 64'h0;
      1: return 64'h8000_0000_0000_0000;
      2: return 64'h7ff0_0000_0000_0000;
      3: return 64'h7ff8_0000_0000_0001;
      4: return 64'h7ff0_0000_0000_0001 | {$urandom & 32'h8000_0000, 32'h0};
      5: return {32'h0000_0000, $urandom} | {$urandom & 32'h8000_0000, 32'h0};
      6: return {32'h3ff0_0000 | ($urandom & 32'h8000_0001), 32'h0};
      default: return {$urandom, $urandom};
    endcase
  endfunction

  initial begin : watchdog
    #(5.0 * 150000);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    check("R1 reset condReg", {32'h0, condReg}, 64'h0);
    check("R1 reset invalidFlag", {63'h0, invalidFlag}, 64'h0);

    doTxn(1, 2'b00, 2'b00, 3'd0, 64'h0, 64'h8000_0000, "R5 +0 eq -0 R7 top nibble");
    doTxn(1, 2'b00, 2'b01, 3'd7, 64'h3f80_0000, 64'h0000_0001, "R2 gt R7 low nibble");
    doTxn(1, 2'b11, 2'b10, 3'd3, 64'h8000_0002, 64'h8000_0001, "R2 mode11 lt subnormal R5");
    doTxn(1, 2'b00, 2'b00, 3'd5, 64'h7f80_0001, 64'h3f80_0000, "R4 snan eq");
    doTxn(1, 2'b00, 2'b01, 3'd5, 64'h7fc0_0000, 64'h3f80_0000, "R4 qnan gt");
    doTxn(1, 2'b01, 2'b01, 3'd2, 64'h3ff0_0000_0000_0000, 64'h3fe0_0000_0000_0000, "R3 double gt");
    doTxn(1, 2'b01, 2'b00, 3'd2, 64'h3ff0_0000_0000_0001, 64'h3ff0_0000_0000_0000, "R3 low bits differ");
    doTxn(0, 2'b00, 2'b00, 3'd0, 64'h1, 64'h1, "R9 no strobe");
    doTxn(1, 2'b00, 2'b00, 3'd4, 64'h7f80_0001, 64'h0, "R10 set");
    doTxn(0, 2'b00, 2'b00, 3'd4, 64'h0, 64'h0, "R9 invalid held");
    doTxn(1, 2'b10, 2'b00, 3'd1, {32'h4000_0000, 32'h3f80_0000},
          {32'h4000_0000, 32'hbf80_0000}, "R6 only high equal");
    doTxn(1, 2'b10, 2'b01, 3'd6, {32'h3f80_0000, 32'h4000_0000},
          {32'h4000_0000, 32'h3f80_0000}, "R6 only low gt");
    doTxn(1, 2'b10, 2'b10, 3'd6, {32'h3f80_0000, 32'h3f80_0000},
          {32'h4000_0000, 32'h4000_0000}, "R6 both lt");
    doTxn(1, 2'b10, 2'b00, 3'd0, {32'h3f80_0000, 32'h7f80_0002},
          {32'h3f80_0000, 32'h0}, "R6 R10 snan low lane");
    doTxn(1, 2'b10, 2'b00, 3'd0, {32'h7fa0_0000, 32'h0},
          {32'h3f80_0000, 32'h8000_0000}, "R6 R10 snan high lane");
    doTxn(1, 2'b00, 2'b11, 3'd3, 64'h0, 64'h0, "R2 test11 never matches R8");

    for (int i = 0; i < 3000; i++) begin
      logic [1:0] m = 2'($urandom);
      logic [63:0] a, b;
      int pick = $urandom % 8;
      string req;
      if (m == 2'b01) begin a = pickDp(); b = pickDp(); end
      else begin a = {pickSp(), pickSp()}; b = {pickSp(), pickSp()}; end
      if (pick < 2) b = a;
      else if (pick == 2) b = a ^ ((m == 2'b01) ? 64'h8000_0000_0000_0000 : 64'h8000_0000_8000_0000);
      req = (m == 2'b01) ? "R3 random double" : (m == 2'b10) ? "R6 random paired" : "R2 random single";
      doTxn(($urandom % 6) != 0, m, 2'($urandom), 3'($urandom), a, b, req);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule